// File: doc/BRIEF.md
# Indexed Interrupt Routing Register File

This block is the software-visible register file of an interrupt routing controller. The bus sees only two 32-bit locations: an 8-bit index register and a data window. Each data access goes to whichever register the index currently names. These are an identity register, a read-only capability word, an arbitration identity register, or one half of a table of 64-bit routing entries. Each table entry takes two adjacent index values. The even index is the lower word and the odd index is the upper word.

All table entries are driven in parallel on a flat output bus, so the routing logic downstream can read every line's entry without using the bus. Fields that software may not set are forced to zero on every table write. Malformed bus accesses raise a one-cycle error pulse. Accesses through the window to an index with no register behind it raise a one-cycle warning pulse.

Top module: `irq_route_regs`

## Requirements
- R1: After reset the index register is 0, the identity and arbitration identity both hold the parameter `ID_RST` (at most 15), and every table entry is zero.
- R2: A full-width write at offset 0 loads the index register from write data bits 7:0. A read at offset 0 returns the index zero-extended to 32 bits.
- R3: An access at any offset other than 0 or 16, or with byte enables other than 4'hF, pulses `err_o` for one cycle, changes no state, and returns 0 if it is a read.
- R4: Index 0x00 holds a 4-bit identity in bits 27:24. A write takes write data bits 27:24, and a read returns all other bits as zero.
- R5: Index 0x01 reads as (NUM_ENT-1) in bits 23:16 and 0x14 in bits 7:0, which is 0x00170014 for 24 entries. Writes to it change nothing.
- R6: Index 0x02 holds a 4-bit arbitration identity in bits 27:24 and is independent of the identity at index 0x00.
- R7: Index 0x10+2k selects bits 31:0 of entry k and index 0x11+2k selects bits 63:32. A write to one half leaves the other half and all other entries unchanged, and `table_o[64k +: 64]` shows entry k. Without a bus request the table does not change.
- R8: A write to a lower half stores only write data bits 16:0 and clears entry bits 31:17.
- R9: A write to an upper half stores only write data bits 31:24 into entry bits 63:56 and clears entry bits 55:32.
- R10: A window access whose index is 0x03 to 0x0F or at or above 0x10+2*NUM_ENT reads 0, ignores writes, and pulses `warn_o` for one cycle. `warn_o` and `err_o` never rise together.
- R11: Each read request, legal or not, gives `rvalid_o` high for exactly the next cycle, with `rdata_o` valid in that cycle. Writes never raise `rvalid_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access request, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte offset within the block |
| be_i | input | 4 | Byte enables; must be 4'hF |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid while rvalid_o is high |
| rvalid_o | output | 1 | Read response strobe, one cycle after the request |
| err_o | output | 1 | Illegal access pulse |
| warn_o | output | 1 | Undefined-index pulse |
| table_o | output | NUM_ENT*64 | All routing entries, entry k in bits 64k+63:64k |

## Verification
The checker watches these properties on every cycle: the one-cycle response timing of reads, the rule that a write never returns a response, the error pulse after malformed requests, the exclusion of error and warning, the table holding still while the bus is idle, and the reserved table bits staying zero. The bench scenarios are needed to show the value side: that the index steers data to the right register and the right half-entry, that a half write leaves its partner alone, that the read-only and undefined indices really discard writes, and the reset contents.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  localparam logic [7:0]  IDX_ID       = 8'h00;
  localparam logic [7:0]  IDX_CAP      = 8'h01;
  localparam logic [7:0]  IDX_ARB      = 8'h02;
  localparam logic [7:0]  IDX_TBL_BASE = 8'h10;
  localparam logic [7:0]  CAP_VERSION  = 8'h14;
  localparam logic [31:0] LO_KEEP      = 32'h0001_FFFF;
  localparam logic [31:0] HI_KEEP      = 32'hFF00_0000;

  typedef enum logic [1:0] {PORT_SEL, PORT_WIN, PORT_BAD} port_e;
  typedef enum logic [2:0] {TGT_NONE, TGT_ID, TGT_CAP, TGT_ARB, TGT_TBL} tgt_e;
endpackage

// File: rtl/irq_bus_decode.sv
module irq_bus_decode
  import irq_route_pkg::*;
#(
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned NUM_ENT = 24,
  localparam int unsigned ENT_W  = $clog2(NUM_ENT)
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [3:0]        be_i,
  input  logic [7:0]        sel_i,
  output port_e             port_o,
  output tgt_e              tgt_o,
  output logic [ENT_W-1:0]  ent_o,
  output logic              hi_o
);
  localparam int unsigned TBL_END = 16 + 2 * NUM_ENT;

  logic       full;
  logic [7:0] rel;

  assign full = (be_i == 4'hF);
  assign rel  = sel_i - IDX_TBL_BASE;

  always_comb begin
    if (full && addr_i == ADDR_W'(0))       port_o = PORT_SEL;
    else if (full && addr_i == ADDR_W'(16)) port_o = PORT_WIN;
    else                                    port_o = PORT_BAD;
  end

  always_comb begin
    if (sel_i == IDX_ID)       tgt_o = TGT_ID;
    else if (sel_i == IDX_CAP) tgt_o = TGT_CAP;
    else if (sel_i == IDX_ARB) tgt_o = TGT_ARB;
    else if (sel_i >= IDX_TBL_BASE && 32'(sel_i) < TBL_END) tgt_o = TGT_TBL;
    else                       tgt_o = TGT_NONE;
  end

  assign ent_o = ENT_W'(rel >> 1);
  assign hi_o  = rel[0];
endmodule

// File: rtl/irq_id_regs.sv
module irq_id_regs #(
  parameter logic [3:0] ID_RST = 4'd0
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sel_we_i,
  input  logic [7:0] sel_d_i,
  input  logic       id_we_i,
  input  logic       arb_we_i,
  input  logic [3:0] id_d_i,
  output logic [7:0] sel_o,
  output logic [3:0] id_o,
  output logic [3:0] arb_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_o <= 8'h00;
      id_o  <= ID_RST;
      arb_o <= ID_RST;
    end else begin
      if (sel_we_i) sel_o <= sel_d_i;
      if (id_we_i)  id_o  <= id_d_i;
      if (arb_we_i) arb_o <= id_d_i;
    end
  end
endmodule

// File: rtl/irq_redir_table.sv
module irq_redir_table
  import irq_route_pkg::*;
#(
  parameter int unsigned NUM_ENT = 24,
  localparam int unsigned ENT_W  = $clog2(NUM_ENT)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   we_i,
  input  logic [ENT_W-1:0]       ent_i,
  input  logic                   hi_i,
  input  logic [31:0]            wdata_i,
  output logic [31:0]            rdata_o,
  output logic [NUM_ENT*64-1:0]  table_o
);
  logic [63:0] ent_q [NUM_ENT];

  for (genvar g = 0; g < NUM_ENT; g++) begin : g_ent
    logic hit;
    assign hit = we_i && (int'(ent_i) == g);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ent_q[g] <= 64'h0;
      end else if (hit) begin
        if (hi_i) ent_q[g][63:32] <= wdata_i & HI_KEEP;
        else      ent_q[g][31:0]  <= wdata_i & LO_KEEP;
      end
    end

    assign table_o[g*64 +: 64] = ent_q[g];
  end

  always_comb begin
    rdata_o = 32'h0;
    if (int'(ent_i) < NUM_ENT) begin
      rdata_o = hi_i ? ent_q[ent_i][63:32] : ent_q[ent_i][31:0];
    end
  end
endmodule

// File: rtl/irq_route_regs.sv
module irq_route_regs
  import irq_route_pkg::*;
#(
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned NUM_ENT = 24,
  parameter logic [3:0]  ID_RST  = 4'd0
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  req_i,
  input  logic                  we_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [3:0]            be_i,
  input  logic [31:0]           wdata_i,
  output logic [31:0]           rdata_o,
  output logic                  rvalid_o,
  output logic                  err_o,
  output logic                  warn_o,
  output logic [NUM_ENT*64-1:0] table_o
);
  localparam int unsigned ENT_W   = $clog2(NUM_ENT);
  localparam logic [31:0] CAP_WORD = {8'h00, 8'(NUM_ENT - 1), 8'h00, CAP_VERSION};

  port_e            port;
  tgt_e             tgt;
  logic [ENT_W-1:0] ent;
  logic             hi;
  logic [7:0]       sel_q;
  logic [3:0]       id_q, arb_q;
  logic [31:0]      tbl_rd, rd_mux;
  logic             wr, rd, win;

  assign wr  = req_i && we_i;
  assign rd  = req_i && !we_i;
  assign win = (port == PORT_WIN);

  irq_bus_decode #(.ADDR_W(ADDR_W), .NUM_ENT(NUM_ENT)) u_dec (
    .addr_i (addr_i),
    .be_i   (be_i),
    .sel_i  (sel_q),
    .port_o (port),
    .tgt_o  (tgt),
    .ent_o  (ent),
    .hi_o   (hi)
  );

  irq_id_regs #(.ID_RST(ID_RST)) u_ids (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sel_we_i (wr && port == PORT_SEL),
    .sel_d_i  (wdata_i[7:0]),
    .id_we_i  (wr && win && tgt == TGT_ID),
    .arb_we_i (wr && win && tgt == TGT_ARB),
    .id_d_i   (wdata_i[27:24]),
    .sel_o    (sel_q),
    .id_o     (id_q),
    .arb_o    (arb_q)
  );

  irq_redir_table #(.NUM_ENT(NUM_ENT)) u_tbl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (wr && win && tgt == TGT_TBL),
    .ent_i   (ent),
    .hi_i    (hi),
    .wdata_i (wdata_i),
    .rdata_o (tbl_rd),
    .table_o (table_o)
  );

  always_comb begin
    rd_mux = 32'h0;
    unique case (port)
      PORT_SEL: rd_mux = {24'h0, sel_q};
      PORT_WIN: begin
        unique case (tgt)
          TGT_ID:  rd_mux = {4'h0, id_q, 24'h0};
          TGT_CAP: rd_mux = CAP_WORD;
          TGT_ARB: rd_mux = {4'h0, arb_q, 24'h0};
          TGT_TBL: rd_mux = tbl_rd;
          default: rd_mux = 32'h0;
        endcase
      end
      default: rd_mux = 32'h0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o  <= 32'h0;
      rvalid_o <= 1'b0;
      err_o    <= 1'b0;
      warn_o   <= 1'b0;
    end else begin
      rvalid_o <= rd;
      if (rd) rdata_o <= rd_mux;
      err_o    <= req_i && (port == PORT_BAD);
      warn_o   <= req_i && win && (tgt == TGT_NONE);
    end
  end
endmodule

// File: rtl/irq_route_regs_chk.sv
module irq_route_regs_chk #(
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned NUM_ENT = 24
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  req_i,
  input logic                  we_i,
  input logic [ADDR_W-1:0]     addr_i,
  input logic [3:0]            be_i,
  input logic                  rvalid_o,
  input logic                  err_o,
  input logic                  warn_o,
  input logic [NUM_ENT*64-1:0] table_o
);
  function automatic logic [NUM_ENT*64-1:0] rep(input logic [63:0] m);
    logic [NUM_ENT*64-1:0] r;
    for (int k = 0; k < NUM_ENT; k++) r[k*64 +: 64] = m;
    return r;
  endfunction

  localparam logic [NUM_ENT*64-1:0] LO_RSV = rep(64'h0000_0000_FFFE_0000);
  localparam logic [NUM_ENT*64-1:0] HI_RSV = rep(64'h00FF_FFFF_0000_0000);

  logic bad_acc;
  assign bad_acc = (be_i != 4'hF) || (addr_i != ADDR_W'(0) && addr_i != ADDR_W'(16));

  assert_read_resp_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i) |=> rvalid_o);
  assert_resp_source_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> $past(req_i && !we_i));
  assert_illegal_flag_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && bad_acc) |=> err_o);
  assert_flags_apart_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(err_o && warn_o));
  assert_idle_table_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> $stable(table_o));
  assert_lo_reserved_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (table_o & LO_RSV) == '0);
  assert_hi_reserved_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (table_o & HI_RSV) == '0);
endmodule

bind irq_route_regs irq_route_regs_chk #(.ADDR_W(ADDR_W), .NUM_ENT(NUM_ENT)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .req_i    (req_i),
  .we_i     (we_i),
  .addr_i   (addr_i),
  .be_i     (be_i),
  .rvalid_o (rvalid_o),
  .err_o    (err_o),
  .warn_o   (warn_o),
  .table_o  (table_o)
);

// File: tb/irq_route_regs_bench.sv
`timescale 1ns/1ps
module irq_route_regs_bench;
  localparam int unsigned ADDR_W  = 8;
  localparam int unsigned NUM_ENT = 24;
  localparam logic [3:0]  ID_RST  = 4'd5;
  localparam logic [31:0] LO_M    = 32'h0001_FFFF;
  localparam logic [31:0] HI_M    = 32'hFF00_0000;

  logic                  clk = 1'b0;
  logic                  rst_n = 1'b0;
  logic                  req = 1'b0, we = 1'b0;
  logic [ADDR_W-1:0]     addr = '0;
  logic [3:0]            be = 4'h0;
  logic [31:0]           wdata = '0;
  logic [31:0]           rdata;
  logic                  rvalid, err, warn;
  logic [NUM_ENT*64-1:0] tbl;

  int checks = 0;
  int errors = 0;
  logic last_err, last_warn;
  logic [63:0] mdl [NUM_ENT];
  logic [31:0] exp_q [$];
  string       tag_q [$];

  always #4 clk = ~clk;

  irq_route_regs #(.ADDR_W(ADDR_W), .NUM_ENT(NUM_ENT), .ID_RST(ID_RST)) u_irq_route_regs (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr), .be_i(be),
    .wdata_i(wdata), .rdata_o(rdata), .rvalid_o(rvalid), .err_o(err), .warn_o(warn),
    .table_o(tbl)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read data as responses appear
  always @(negedge clk) begin
    if (rst_n && rvalid) begin
      if (exp_q.size() == 0) chk("R11 unexpected rvalid", 64'(rvalid), 64'h0);
      else chk(tag_q.pop_front(), 64'(rdata), 64'(exp_q.pop_front()));
    end
  end

  task automatic acc(input logic w, input logic [7:0] a, input logic [3:0] b, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = w; addr = a; be = b; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
    last_err = err; last_warn = warn;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    acc(1'b1, a, 4'hF, d);
  endtask

  task automatic rd(input logic [7:0] a, input logic [3:0] b, input logic [31:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    acc(1'b0, a, b, 32'h0);
  endtask

  task automatic win_wr(input logic [7:0] idx, input logic [31:0] d);
    wr(8'd0, {24'h0, idx});
    wr(8'd16, d);
  endtask

  task automatic win_rd(input logic [7:0] idx, input logic [31:0] exp, input string tag);
    wr(8'd0, {24'h0, idx});
    rd(8'd16, 4'hF, exp, tag);
  endtask

  task automatic tbl_chk(input string tag);
    logic ok = 1'b1;
    for (int k = 0; k < NUM_ENT; k++) begin
      if (tbl[k*64 +: 64] !== mdl[k]) begin
        ok = 1'b0;
        $display("FAIL %s entry %0d actual=%h expected=%h", tag, k, tbl[k*64 +: 64], mdl[k]);
      end
    end
    checks++;
    if (!ok) errors++;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int k = 0; k < NUM_ENT; k++) mdl[k] = 64'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    tbl_chk("R1 table after reset");
    rd(8'd0, 4'hF, 32'h0, "R1 select after reset");
    rd(8'd16, 4'hF, {4'h0, ID_RST, 24'h0}, "R1 id after reset");
    win_rd(8'h02, {4'h0, ID_RST, 24'h0}, "R1 arb id after reset");

    // R2 select register
    wr(8'd0, 32'hFFFF_FFA7);
    rd(8'd0, 4'hF, 32'h0000_00A7, "R2 select readback");
    chk("R11 no warn on legal", 64'(last_warn), 64'h0);

    // R4 / R6 identity registers
    win_wr(8'h00, 32'hFFFF_FFFF);
    win_rd(8'h00, 32'h0F00_0000, "R4 id bits 27:24 only");
    win_rd(8'h02, {4'h0, ID_RST, 24'h0}, "R6 arb untouched by id write");
    win_wr(8'h02, 32'h3A00_0000);
    win_rd(8'h02, 32'h0A00_0000, "R6 arb write");
    win_rd(8'h00, 32'h0F00_0000, "R4 id untouched by arb write");

    // R5 read-only capability word
    win_rd(8'h01, 32'h0017_0014, "R5 capability");
    win_wr(8'h01, 32'hFFFF_FFFF);
    win_rd(8'h01, 32'h0017_0014, "R5 capability after write");

    // R7 / R8 / R9 table halves
    win_wr(8'h10, 32'hFFFF_FFFF);
    mdl[0][31:0] = 32'hFFFF_FFFF & LO_M;
    win_rd(8'h10, 32'h0001_FFFF, "R8 low half reserved cleared");
    tbl_chk("R7 table after entry 0 low");
    win_wr(8'h11, 32'hFFFF_FFFF);
    mdl[0][63:32] = 32'hFFFF_FFFF & HI_M;
    win_rd(8'h11, 32'hFF00_0000, "R9 high half reserved cleared");
    win_rd(8'h10, 32'h0001_FFFF, "R7 low half kept after high write");
    win_wr(8'h3E, 32'h1234_5678);
    mdl[23][31:0] = 32'h1234_5678 & LO_M;
    win_wr(8'h3F, 32'hABCD_EF01);
    mdl[23][63:32] = 32'hABCD_EF01 & HI_M;
    tbl_chk("R7 last entry and neighbours");
    win_rd(8'h3F, 32'hAB00_0000, "R9 last entry high");
    win_wr(8'h25, 32'h5A00_0000);
    mdl[10][63:32] = 32'h5A00_0000;
    tbl_chk("R7 odd index maps to entry 10 high");

    // R10 undefined indices
    win_rd(8'h40, 32'h0, "R10 read above table");
    chk("R10 warn above table", 64'(last_warn), 64'h1);
    chk("R10 no err with warn", 64'(last_err), 64'h0);
    win_wr(8'h40, 32'hFFFF_FFFF);
    chk("R10 warn on write", 64'(last_warn), 64'h1);
    tbl_chk("R10 table after ignored write");
    win_wr(8'h05, 32'hFFFF_FFFF);
    win_rd(8'h05, 32'h0, "R10 read gap index");
    chk("R10 warn gap index", 64'(last_warn), 64'h1);
    win_rd(8'h00, 32'h0F00_0000, "R10 id after gap write");
    win_rd(8'h02, 32'h0A00_0000, "R10 arb after gap write");

    // R3 illegal accesses
    wr(8'd0, 32'h0000_0002);
    acc(1'b1, 8'd4, 4'hF, 32'h0000_0011);
    chk("R3 err on bad offset write", 64'(last_err), 64'h1);
    rd(8'd16, 4'hF, 32'h0A00_0000, "R3 select unchanged");
    rd(8'd8, 4'hF, 32'h0, "R3 bad offset read data");
    chk("R3 err on bad offset read", 64'(last_err), 64'h1);
    chk("R3 no warn on bad offset", 64'(last_warn), 64'h0);
    acc(1'b1, 8'd16, 4'h3, 32'h0100_0000);
    chk("R3 err on partial write", 64'(last_err), 64'h1);
    rd(8'd16, 4'hF, 32'h0A00_0000, "R3 arb unchanged after partial write");
    rd(8'd0, 4'h1, 32'h0, "R3 partial read data");
    chk("R3 err on partial read", 64'(last_err), 64'h1);
    tbl_chk("R3 table unchanged");

    // R11 responses drained; idle cycles give no response
    repeat (4) @(negedge clk);
    chk("R11 queue drained", 64'(exp_q.size()), 64'h0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule